// File: doc/BRIEF.md
# Lockable Thermal Calibration Offset Unit

This unit keeps one 8-bit control register on a thermal sensor path. The low seven bits are a signed two's complement calibration offset. The top bit is a one-way lock. The offset is widened to nine bits by copying its sign bit. It is then added to an external free-running 9-bit temperature count, and the registered sum drives the input code of a sensor DAC.

The two fields are reset separately, each by its own active-low asynchronous reset. The platform reset clears only the lock. The power-good reset loads the offset from a fuse input and leaves the lock as it is. Software can set the lock but never clear it. Once the lock is set, every write to the register is dropped. The lock level is brought out so that neighbouring registers can freeze their own fields with it.

Top module: `thermal_offset_unit`

## Requirements
- R1: While the platform reset is low, the lock bit and `lock_o` are 0. When the power-good reset is low, the offset loads the value on `fuse_ofs_i`.
- R2: A write while unlocked with `wr_data_i[7]`=1 sets the lock on that clock edge. The same write also stores `wr_data_i[6:0]` as the offset.
- R3: Writing 0 to bit 7 never clears or changes the lock.
- R4: While the lock is set, writes change neither the lock nor the offset.
- R5: The power-good reset does not alter the lock. The platform reset does not alter the offset.
- R6: A write while unlocked stores `wr_data_i[6:0]` on the edge where `wr_en_i` is high. `rd_data_o` always reads {lock, offset}.
- R7: The offset is sign-extended from bit 6. Values 00h..3Fh are 0..63, 40h is -64, 41h is -63, and 7Fh is -1.
- R8: `dac_code_o` equals (counter + extended offset) mod 512, both taken at the previous clock edge. The power-good reset clears it to 0.
- R9: `lock_o` equals bit 7 of `rd_data_o` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| plat_rst_ni | input | 1 | Platform reset, active low, asynchronous; clears the lock |
| pwr_rst_ni | input | 1 | Power-good reset, active low, asynchronous; loads the offset and clears the DAC code |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data: bit 7 lock, bits 6:0 offset |
| rd_data_o | output | 8 | Read data {lock, offset} |
| fuse_ofs_i | input | 7 | Fused offset default |
| temp_cnt_i | input | 9 | Temperature counter value |
| dac_code_o | output | 9 | Registered DAC input code |
| lock_o | output | 1 | Lock level for other protected fields |

## Verification
The bench writes the boundary offsets 3Fh, 40h, 41h and 7Fh against counter values chosen so that the sum wraps past 511 and below 0. A design that extends the sign wrongly, or that saturates instead of wrapping, gives codes that do not match. One write sets the lock and changes the offset in the same cycle, and later writes with bit 7 at 0 or 1 must all be dropped. A design that checks the lock one cycle late, or that lets bit 7 be written back to 0, is caught by the readback. Each reset is pulsed alone to show that it touches only its own field. A design wired to the wrong reset domain loses the lock on power-good or the offset on platform reset.

// File: rtl/tco_pkg.sv
package tco_pkg;
  localparam int unsigned OFS_W  = 7;
  localparam int unsigned CODE_W = 9;
  localparam int unsigned REG_W  = OFS_W + 1;

  typedef logic [OFS_W-1:0]  ofs_t;
  typedef logic [CODE_W-1:0] code_t;

  function automatic code_t sext_ofs(input ofs_t o);
    return {{(CODE_W-OFS_W){o[OFS_W-1]}}, o};
  endfunction
endpackage

// File: rtl/tco_lock_reg.sv
module tco_lock_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_lock_i,
  output logic lock_o
);
  logic lock_q;

  // set-only; cleared solely by the platform reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         lock_q <= 1'b0;
    else if (wr_en_i && !lock_q && wr_lock_i) lock_q <= 1'b1;
  end

  assign lock_o = lock_q;

  a_r2_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);

  a_r2_lock_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_lock_i) |=> lock_q);

  a_r3_zero_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_q && !(wr_en_i && wr_lock_i)) |=> !lock_q);
endmodule

// File: rtl/tco_ofs_reg.sv
module tco_ofs_reg
  import tco_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic plat_rst_ni,
  input  logic wr_en_i,
  input  ofs_t wr_ofs_i,
  input  logic lock_i,
  input  ofs_t fuse_i,
  output ofs_t ofs_o
);
  ofs_t ofs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ofs_q <= fuse_i;
    else if (wr_en_i && !lock_i) ofs_q <= wr_ofs_i;
  end

  assign ofs_o = ofs_q;

  a_r4_locked_hold: assert property (@(posedge clk_i)
    disable iff (!rst_ni || !plat_rst_ni)
    lock_i |=> $stable(ofs_q));

  a_r6_write_takes: assert property (@(posedge clk_i)
    disable iff (!rst_ni || !plat_rst_ni)
    (wr_en_i && !lock_i) |=> (ofs_q == $past(wr_ofs_i)));
endmodule

// File: rtl/tco_dac_sum.sv
module tco_dac_sum
  import tco_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  code_t cnt_i,
  input  ofs_t  ofs_i,
  output code_t code_o
);
  code_t code_q;
  logic  seen_q;

  // modulo 2^CODE_W, no saturation
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      seen_q <= 1'b0;
    end else begin
      code_q <= cnt_i + sext_ofs(ofs_i);
      seen_q <= 1'b1;
    end
  end

  assign code_o = code_q;

  a_r8_dac_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (code_q == code_t'($past(cnt_i) + {{(CODE_W-OFS_W){$past(ofs_i[OFS_W-1])}}, $past(ofs_i)})));
endmodule

// File: rtl/thermal_offset_unit.sv
module thermal_offset_unit
  import tco_pkg::*;
(
  input  logic              clk_i,
  input  logic              plat_rst_ni,
  input  logic              pwr_rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic [OFS_W-1:0]  fuse_ofs_i,
  input  logic [CODE_W-1:0] temp_cnt_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              lock_o
);
  logic lock;
  ofs_t ofs;

  tco_lock_reg u_lock (
    .clk_i    (clk_i),
    .rst_ni   (plat_rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_lock_i(wr_data_i[REG_W-1]),
    .lock_o   (lock)
  );

  tco_ofs_reg u_ofs (
    .clk_i      (clk_i),
    .rst_ni     (pwr_rst_ni),
    .plat_rst_ni(plat_rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_ofs_i   (wr_data_i[OFS_W-1:0]),
    .lock_i     (lock),
    .fuse_i     (fuse_ofs_i),
    .ofs_o      (ofs)
  );

  tco_dac_sum u_dac (
    .clk_i (clk_i),
    .rst_ni(pwr_rst_ni),
    .cnt_i (temp_cnt_i),
    .ofs_i (ofs),
    .code_o(dac_code_o)
  );

  assign rd_data_o = {lock, ofs};
  assign lock_o    = lock;

  a_r9_lock_out: assert property (@(posedge clk_i) disable iff (!plat_rst_ni)
    lock_o == rd_data_o[REG_W-1]);
endmodule

// File: tb/thermal_offset_unit_tb.sv
module thermal_offset_unit_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       plat_rst_n = 1'b0;
  logic       pwr_rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [6:0] fuse = 7'h41;
  logic [8:0] cnt = '0;
  logic [8:0] dac;
  logic       lock;

  int n_chk = 0;
  int n_fail = 0;
  logic [8:0] exp_q[$];
  logic       m_lock = 1'b0;
  logic [6:0] m_ofs = 7'h41;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_offset_unit u_dut (
    .clk_i      (clk),
    .plat_rst_ni(plat_rst_n),
    .pwr_rst_ni (pwr_rst_n),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .rd_data_o  (rd_data),
    .fuse_ofs_i (fuse),
    .temp_cnt_i (cnt),
    .dac_code_o (dac),
    .lock_o     (lock)
  );

  function automatic logic [8:0] ext9(input logic [6:0] v);
    return v[6] ? (9'd0 - 9'(8'd128 - {1'b0, v})) : {2'b00, v};
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_reg(input string req);
    check(req, {1'b0, rd_data}, {1'b0, m_lock, m_ofs});
    check("R9", {8'd0, lock}, {8'd0, m_lock});
  endtask

  // driver: one cycle of stimulus, expected DAC code pushed to scoreboard
  task automatic cyc(input logic we, input logic [7:0] wd, input logic [8:0] c, input string req);
    @(negedge clk);
    wr_en = we; wr_data = wd; cnt = c;
    @(posedge clk);
    #1;
    exp_q.push_back(c + ext9(m_ofs));
    if (we && !m_lock) begin
      m_ofs = wd[6:0];
      if (wd[7]) m_lock = 1'b1;
    end
    chk_reg(req);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // monitor: compares DAC code against scoreboard
  always @(negedge clk) begin
    if (exp_q.size() > 0) check("R8", dac, exp_q.pop_front());
  end

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    #(CLK_PERIOD*3);
    plat_rst_n = 1'b1; pwr_rst_n = 1'b1;
    #1;
    // R1: reset state
    chk_reg("R1");
    check("R1", dac, 9'd0);

    cyc(1'b0, 8'h00, 9'd100, "R7");           // 100 + (-63) = 37
    cyc(1'b1, 8'h05, 9'd0, "R6");             // R3: bit7=0 leaves unlocked
    cyc(1'b0, 8'h00, 9'h1FF, "R8");           // 511 + 5 wraps to 4
    cyc(1'b1, 8'h40, 9'd10, "R7");            // -64
    cyc(1'b0, 8'h00, 9'd10, "R7");            // 10-64 wraps to 458
    cyc(1'b1, 8'h7F, 9'd0, "R7");             // -1
    cyc(1'b0, 8'h00, 9'd0, "R7");             // 511
    cyc(1'b1, 8'h3F, 9'h1C1, "R6");
    cyc(1'b0, 8'h00, 9'h1C1, "R8");           // 0x1C1+0x3F = 0x200 -> 0
    cyc(1'b1, 8'h41, 9'd63, "R7");
    cyc(1'b0, 8'h00, 9'd63, "R7");            // 63-63 = 0
    cyc(1'b1, 8'hAA, 9'd7, "R2");             // lock and offset 2Ah same edge
    cyc(1'b1, 8'h15, 9'd7, "R4");             // ignored
    cyc(1'b1, 8'h00, 9'd8, "R3");             // ignored, lock stays
    for (int i = 0; i < 20; i++) cyc(1'b1, 8'(i * 13), 9'(i * 37), "R4");

    // R5: power-good reset keeps lock, reloads offset from fuse
    @(negedge clk); #2;
    fuse = 7'h10;
    pwr_rst_n = 1'b0;
    exp_q.delete();
    #1;
    m_ofs = 7'h10;
    chk_reg("R5");
    check("R8", dac, 9'd0);
    @(negedge clk); #2;
    pwr_rst_n = 1'b1;
    cyc(1'b1, 8'h01, 9'd20, "R4");
    cyc(1'b0, 8'h00, 9'd20, "R8");

    // R5: platform reset clears lock, keeps offset
    @(negedge clk); #2;
    plat_rst_n = 1'b0;
    #1;
    m_lock = 1'b0;
    chk_reg("R5");
    @(negedge clk); #2;
    plat_rst_n = 1'b1;
    cyc(1'b1, 8'h03, 9'd30, "R6");
    cyc(1'b0, 8'h00, 9'd30, "R8");
    cyc(1'b1, 8'h83, 9'd30, "R2");
    cyc(1'b1, 8'h7F, 9'd30, "R4");
    repeat (3) @(negedge clk);
    summary();
  end
endmodule